// File: doc/BRIEF.md
# Display Run/Stop and Shadow-Update Controller

This block sequences the start and stop of a display pipeline and decides the moment at which software-written layer configuration becomes the configuration the pipeline actually uses. Software writes a small staging bank of configuration words, a control word and a one-bit interface-select word. The timing side reports frame-boundary events and transfer-complete events. The block drives the live configuration bank, a one-cycle strobe when that bank is reloaded, and pulses for commit-complete and for pipeline-done.

Two interface modes exist. In continuous video mode the live bank acts as a shadow of the staging bank: an update request is held pending and is applied at the next frame boundary, so the live values never change in the middle of a frame. In command mode there is no shadowing. Each rising edge of the run state copies the staging bank into the live bank and starts one frame transfer. The hardware then clears the run state when the transfer completes, so the next run write starts the next frame.

Top module: `disp_run_ctrl`

## Requirements
- R1: After reset the block is stopped, video mode is selected, no update or stop is pending, every live word is zero and all pulse outputs are low.
- R2: Control word bit 0 is run, bit 1 is stop and bit 2 is update request. A run write while stopped makes `running` high on the next cycle, and a run write while running has no effect. The mode word bit 0 selects command mode when 1 and video mode when 0. A mode write is ignored while running or while an update is pending.
- R3: In command mode the staging bank is copied to `live_cfg` only on the stopped-to-running transition. `live_load` pulses in the cycle in which `running` first reads high.
- R4: In video mode an accepted update request sets `upd_pending`. On the next `frame_start` the staging bank is copied to `live_cfg`, and `live_load` and `upd_done` pulse for one cycle after that edge. No other event changes the live bank in video mode.
- R5: The update request clears itself when the copy is made. Update writes that arrive while one is already pending, including in the commit cycle, are ignored, and they cause no second copy.
- R6: Writes to the staging bank never change `live_cfg` by themselves.
- R7: In video mode a stop write while running is held pending. At the next `frame_start`, `running` falls and `done` pulses for one cycle.
- R8: In command mode `xfer_done` while running clears `running` and pulses `done`. A later run write starts a new frame and reloads the live bank from the current staging values.
- R9: In command mode the stop and update-request bits, and `frame_start`, have no effect. In video mode `xfer_done` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 3 | Control word: bit 0 run, bit 1 stop, bit 2 update request |
| cfg_we | input | 1 | Mode word write strobe |
| cfg_wdata | input | 1 | 1 selects command mode, 0 selects video mode |
| stg_we | input | 1 | Staging bank write strobe |
| stg_addr | input | AW | Staging word index |
| stg_wdata | input | DW | Staging word data |
| frame_start | input | 1 | Frame boundary (vertical sync start) event |
| xfer_done | input | 1 | Single-frame transfer complete event |
| cmd_mode | output | 1 | Current mode, 1 for command mode |
| running | output | 1 | Pipeline run state |
| upd_pending | output | 1 | Video-mode update request awaiting a frame boundary |
| live_cfg | output | NREG*DW | Live configuration bank, word i at bits i*DW upward |
| live_load | output | 1 | One-cycle strobe: live bank was reloaded |
| upd_done | output | 1 | One-cycle pulse: video-mode commit complete |
| done | output | 1 | One-cycle pulse: output stopped or frame transfer complete |

## Verification
On every cycle, the assertions check four things: the live bank holds still whenever no reload strobe is shown, a commit pulse always follows a frame boundary and leaves nothing pending, a command-mode reload coincides with the run rising edge, and a done pulse is never seen together with the run state. Only the bench scenarios can show the rest. These include the commit landing on the frame boundary after the request rather than a later one, and duplicate update writes producing no second copy. They also include mode writes being refused while busy, and the command-mode stop and update bits leaving every output untouched. A reference model is compared against all outputs on every cycle under random traffic.

// File: rtl/disp_run_ctrl.sv
module disp_run_ctrl #(
  parameter int NREG = 4,
  parameter int DW   = 8,
  localparam int AW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_we,
  input  logic [2:0]           ctl_wdata,
  input  logic                 cfg_we,
  input  logic                 cfg_wdata,
  input  logic                 stg_we,
  input  logic [AW-1:0]        stg_addr,
  input  logic [DW-1:0]        stg_wdata,
  input  logic                 frame_start,
  input  logic                 xfer_done,
  output logic                 cmd_mode,
  output logic                 running,
  output logic                 upd_pending,
  output logic [NREG*DW-1:0]   live_cfg,
  output logic                 live_load,
  output logic                 upd_done,
  output logic                 done
);

  logic stop_pend;

  wire run_set  = ctl_we && ctl_wdata[0] && !running;
  wire stop_req = ctl_we && ctl_wdata[1] && running && !cmd_mode && !stop_pend;
  wire upd_req  = ctl_we && ctl_wdata[2] && !cmd_mode && !upd_pending;
  wire commit_v = !cmd_mode && frame_start && upd_pending;
  wire stop_v   = !cmd_mode && frame_start && stop_pend;
  wire end_c    = cmd_mode && xfer_done && running;
  wire cfg_ok   = cfg_we && !running && !upd_pending;
  wire load     = commit_v || (cmd_mode && run_set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_mode    <= 1'b0;
      running     <= 1'b0;
      upd_pending <= 1'b0;
      stop_pend   <= 1'b0;
      live_load   <= 1'b0;
      upd_done    <= 1'b0;
      done        <= 1'b0;
    end else begin
      if (cfg_ok) cmd_mode <= cfg_wdata;
      if (run_set) running <= 1'b1;
      else if (stop_v || end_c) running <= 1'b0;
      if (commit_v) upd_pending <= 1'b0;
      else if (upd_req) upd_pending <= 1'b1;
      if (stop_v) stop_pend <= 1'b0;
      else if (stop_req) stop_pend <= 1'b1;
      live_load <= load;
      upd_done  <= commit_v;
      done      <= stop_v || end_c;
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_bank
    logic [DW-1:0] stg_q, live_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q  <= '0;
        live_q <= '0;
      end else begin
        if (stg_we && stg_addr == AW'(i)) stg_q <= stg_wdata;
        if (load) live_q <= stg_q;
      end
    end
    assign live_cfg[i*DW +: DW] = live_q;
  end

  AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !live_load |-> $stable(live_cfg)); // R6
  AST_COMMIT_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> ($past(frame_start) && live_load)); // R4
  AST_REQ_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> !upd_pending); // R5
  AST_CMD_LOAD_ON_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (live_load && cmd_mode) |-> $rose(running)); // R3
  AST_DONE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !running); // R7

endmodule

// File: tb/tb_disp_run_ctrl.sv
`timescale 1ns/1ps
module tb_disp_run_ctrl;
  localparam int NREG = 4;
  localparam int DW   = 8;

  logic clk = 0, rst_n = 0;
  logic ctl_we = 0, cfg_we = 0, cfg_wdata = 0, stg_we = 0, frame_start = 0, xfer_done = 0;
  logic [2:0] ctl_wdata = 0;
  logic [1:0] stg_addr = 0;
  logic [DW-1:0] stg_wdata = 0;
  logic cmd_mode, running, upd_pending, live_load, upd_done, done;
  logic [NREG*DW-1:0] live_cfg;

  int checks = 0, failures = 0, cycles = 0;

  logic m_cmd, m_run, m_pend, m_spend, m_ld, m_ud, m_dn;
  logic [DW-1:0] m_stg [NREG];
  logic [DW-1:0] m_live [NREG];

  disp_run_ctrl #(.NREG(NREG), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .stg_we(stg_we), .stg_addr(stg_addr),
    .stg_wdata(stg_wdata), .frame_start(frame_start), .xfer_done(xfer_done),
    .cmd_mode(cmd_mode), .running(running), .upd_pending(upd_pending),
    .live_cfg(live_cfg), .live_load(live_load), .upd_done(upd_done), .done(done));

  always #2 clk = ~clk;

  function automatic logic [NREG*DW-1:0] exp_live();
    logic [NREG*DW-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*DW +: DW] = m_live[i];
    return v;
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cmd = 0; m_run = 0; m_pend = 0; m_spend = 0; m_ld = 0; m_ud = 0; m_dn = 0;
    for (int i = 0; i < NREG; i++) begin m_stg[i] = 0; m_live[i] = 0; end
  endtask

  task automatic model_next();
    logic run_set, stop_req, upd_req, commit, stop_v, end_c, load, cfg_ok;
    run_set  = ctl_we && ctl_wdata[0] && !m_run;
    stop_req = ctl_we && ctl_wdata[1] && m_run && !m_cmd && !m_spend;
    upd_req  = ctl_we && ctl_wdata[2] && !m_cmd && !m_pend;
    commit   = !m_cmd && frame_start && m_pend;
    stop_v   = !m_cmd && frame_start && m_spend;
    end_c    = m_cmd && xfer_done && m_run;
    load     = commit || (m_cmd && run_set);
    cfg_ok   = cfg_we && !m_run && !m_pend;
    if (load) for (int i = 0; i < NREG; i++) m_live[i] = m_stg[i];
    if (stg_we) m_stg[stg_addr] = stg_wdata;
    if (cfg_ok) m_cmd = cfg_wdata;
    if (run_set) m_run = 1; else if (stop_v || end_c) m_run = 0;
    if (commit) m_pend = 0; else if (upd_req) m_pend = 1;
    if (stop_v) m_spend = 0; else if (stop_req) m_spend = 1;
    m_ld = load; m_ud = commit; m_dn = stop_v || end_c;
  endtask

  task automatic compare(input string tag);
    chk(tag, "cmd_mode", 64'(cmd_mode), 64'(m_cmd));
    chk(tag, "running", 64'(running), 64'(m_run));
    chk(tag, "upd_pending", 64'(upd_pending), 64'(m_pend));
    chk(tag, "live_cfg", 64'(live_cfg), 64'(exp_live()));
    chk(tag, "live_load", 64'(live_load), 64'(m_ld));
    chk(tag, "upd_done", 64'(upd_done), 64'(m_ud));
    chk(tag, "done", 64'(done), 64'(m_dn));
  endtask

  task automatic cyc(input string tag);
    model_next();
    @(posedge clk); #1;
    compare(tag);
    ctl_we = 0; ctl_wdata = 0; cfg_we = 0; cfg_wdata = 0; stg_we = 0;
    frame_start = 0; xfer_done = 0;
  endtask

  task automatic ctl(input logic [2:0] d, input string tag);
    ctl_we = 1; ctl_wdata = d; cyc(tag);
  endtask

  task automatic stage(input int a, input logic [DW-1:0] d, input string tag);
    stg_we = 1; stg_addr = 2'(a); stg_wdata = d; cyc(tag);
  endtask

  initial begin
    while (cycles < 150000) begin @(posedge clk); cycles++; end
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    // R1 reset state, literal values
    chk("R1", "running", 64'(running), 0);
    chk("R1", "live_cfg", 64'(live_cfg), 0);
    chk("R1", "cmd_mode", 64'(cmd_mode), 0);
    chk("R1", "pulses", 64'({live_load, upd_done, done, upd_pending}), 0);

    // video mode
    for (int i = 0; i < NREG; i++) stage(i, 8'(8'h11 * (i + 1)), "R6");
    chk("R6", "live untouched", 64'(live_cfg), 0);
    ctl(3'b001, "R2");
    chk("R2", "running set", 64'(running), 1);
    cfg_we = 1; cfg_wdata = 1; cyc("R2");
    chk("R2", "mode write while running ignored", 64'(cmd_mode), 0);
    ctl(3'b001, "R2");
    ctl(3'b100, "R4");
    chk("R4", "pending", 64'(upd_pending), 1);
    stage(0, 8'hA5, "R6");
    ctl(3'b100, "R5");
    repeat (3) cyc("R4");
    chk("R4", "no mid-frame copy", 64'(live_cfg), 0);
    frame_start = 1; cyc("R4");
    chk("R4", "commit data", 64'(live_cfg), 64'h4433_22A5);
    chk("R4", "upd_done pulse", 64'(upd_done), 1);
    chk("R5", "self clear", 64'(upd_pending), 0);
    cyc("R4");
    frame_start = 1; cyc("R5");
    chk("R5", "no second copy", 64'(live_load), 0);
    xfer_done = 1; cyc("R9");
    ctl(3'b010, "R7");
    chk("R7", "still running until boundary", 64'(running), 1);
    frame_start = 1; cyc("R7");
    chk("R7", "stopped", 64'(running), 0);
    chk("R7", "done pulse", 64'(done), 1);

    // command mode
    cfg_we = 1; cfg_wdata = 1; cyc("R2");
    chk("R2", "cmd mode", 64'(cmd_mode), 1);
    stage(2, 8'h5C, "R6");
    chk("R6", "live held", 64'(live_cfg), 64'h4433_22A5);
    ctl(3'b001, "R3");
    chk("R3", "load on run edge", 64'(live_cfg), 64'h445C_22A5);
    chk("R3", "live_load", 64'(live_load), 1);
    stage(1, 8'h77, "R6");
    ctl(3'b110, "R9");
    frame_start = 1; cyc("R9");
    chk("R9", "ignored bits", 64'({running, upd_pending, live_load, done}), 64'b1000);
    ctl(3'b001, "R2");
    xfer_done = 1; cyc("R8");
    chk("R8", "run cleared", 64'(running), 0);
    chk("R8", "done", 64'(done), 1);
    ctl(3'b001, "R8");
    chk("R8", "reload", 64'(live_cfg), 64'h445C_77A5);
    xfer_done = 1; cyc("R8");

    // random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      ctl_we = (r < 30); ctl_wdata = 3'($urandom);
      cfg_we = (r >= 95); cfg_wdata = 1'($urandom);
      stg_we = ($urandom_range(0, 3) == 0); stg_addr = 2'($urandom); stg_wdata = 8'($urandom);
      frame_start = ($urandom_range(0, 5) == 0);
      xfer_done = ($urandom_range(0, 5) == 0);
      cyc("R4/R7/R8 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule